// File: doc/BRIEF.md
# Flash Programming Mode Gate

This block decides when a chip may switch into its privileged flash-programming mode, a mode that only the serial slave port can request. It watches the register writes that the serial port delivers at two dedicated addresses: a selector register that names the wanted mode and a key register that fires the request. It combines that write sequence with five hardware gating inputs: a debug-enable pin, a supply-good flag, a preboot flag, a secure flag and a 4-bit unlock field. When the sequence and every gate are right, it raises a sticky active flag and a mode indication, halts the processor and blocks interrupts from the serial transaction path.

Two modes exist. Selector value 0xD1 requests whole-flash erase. The controller then gives the flash controller a one-cycle start pulse and shows a busy flag until the erase-done input comes back. Selector value 0x2E requests read-back. The secure flag refuses read-back but still allows erase. Register writes never leave the mode. Only the chip reset `rst_n` does, and it is the merged watchdog and external-pin reset.

The state machine has five named states. `PG_IDLE` waits for an accepted request. `PG_ERASE_KICK` lasts one cycle and issues the start pulse. `PG_ERASE_WAIT` waits for erase-done. `PG_ERASE_HOLD` is the settled erase mode. `PG_READBACK` is the read-back mode. The transitions are:
- idle→kick on an accepted erase request
- idle→readback on an accepted read-back request
- kick→wait unconditionally
- wait→hold on erase-done

Hold and readback can only be left through reset.

Top module: `flash_pgm_gate`

## Requirements
- R1: A write with `wr_addr` = 0x2080 stores `wr_data` in the selector register. A write with `wr_addr` = 0x2081 is a key write. Writes to any other address change nothing, so a valid selector byte written elsewhere never leads to entry.
- R2: Entry is possible only when the stored selector is 0xD1 (erase, `mode_erase`=1) or 0x2E (read-back, `mode_readback`=1). Every other selector value is refused.
- R3: Entry happens only on a key write whose data is 0x96. All other key values are refused.
- R4: Every key write, whatever its data, clears the stored selector to zero. The entry decision in that same cycle uses the value stored before the clear. A refused key write followed by a 0x96 key write with no new selector write does not enter.
- R5: Entry requires `dbg_en`=1, `supply_ok`=1, `preboot`=0 and `unlock`=4'b0010, all sampled in the key-write cycle.
- R6: With `secure`=1, read-back entry is refused and erase entry is still permitted.
- R7: While `active`=1, `cpu_halt`=1 and `irq_out`=0. While idle, `cpu_halt`=0 and `irq_out` follows `irq_in`.
- R8: Once active, no register write can clear or change the mode. Only `rst_n` low returns the block to idle.
- R9: After an accepted erase request, `erase_start` is high for exactly the one cycle after the key write. `erase_busy` is high from that cycle until the cycle after `erase_done` is seen following the start pulse. An `erase_done` during the start cycle is ignored.
- R10: After reset, `active`, `mode_erase`, `mode_readback`, `cpu_halt`, `erase_start` and `erase_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low merged watchdog/pin reset |
| wr_en | input | 1 | Serial-port register write strobe |
| wr_addr | input | 16 | Serial-port write address |
| wr_data | input | 8 | Serial-port write data |
| dbg_en | input | 1 | Debug-enable pin level |
| supply_ok | input | 1 | Supply above threshold |
| preboot | input | 1 | Preboot flag (must be 0) |
| secure | input | 1 | Secure flag, blocks read-back |
| unlock | input | 4 | Unlock field (must be 4'b0010) |
| erase_done | input | 1 | Flash controller reports erase finished |
| irq_in | input | 1 | Interrupt from the serial transaction path |
| active | output | 1 | Programming mode entered |
| mode_erase | output | 1 | Active in erase mode |
| mode_readback | output | 1 | Active in read-back mode |
| cpu_halt | output | 1 | Processor halt |
| irq_out | output | 1 | Interrupt passed to the processor |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_busy | output | 1 | Erase in progress |

## Verification
Within a single key-write cycle the block both evaluates entry and clears the selector. The evaluation must use the value from before the clear, and the clear must still take effect. The bench provokes this by arming a valid selector and then sweeping all 256 key values, each time with a fresh reset and re-arm. After every refused key it issues a 0x96 key with no new selector write. Only 0x96 may enter, and that second key must never enter, which shows that both the decision and the clear occurred in the same cycle.

// File: rtl/prog_gate_pkg.sv
package prog_gate_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned UNLK_W = 4;

    localparam logic [DATA_W-1:0] SEL_ERASE = 8'hD1;
    localparam logic [DATA_W-1:0] SEL_READ  = 8'h2E;
    localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h96;
    localparam logic [UNLK_W-1:0] UNLK_CODE = 4'b0010;

    typedef enum logic [2:0] {
        PG_IDLE,
        PG_ERASE_KICK,
        PG_ERASE_WAIT,
        PG_ERASE_HOLD,
        PG_READBACK
    } pg_state_e;
endpackage

// File: rtl/pg_wr_decode.sv
module pg_wr_decode
    import prog_gate_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h2080,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h2081
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sel_wr,
    output logic              key_wr,
    output logic              key_ok
);
    always_comb begin
        sel_wr = wr_en && (wr_addr == SEL_ADDR);
        key_wr = wr_en && (wr_addr == KEY_ADDR);
        key_ok = (wr_data == KEY_OPEN);
    end
endmodule

// File: rtl/pg_sel_reg.sv
module pg_sel_reg
    import prog_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sel_erase,
    output logic              sel_read
);
    logic [DATA_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (key_wr) sel_q <= '0;
        else if (sel_wr) sel_q <= wr_data;
    end

    always_comb begin
        sel_erase = (sel_q == SEL_ERASE);
        sel_read  = (sel_q == SEL_READ);
    end

    // R4: a key write always leaves the selector cleared
    assert_key_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (sel_q == '0));
endmodule

// File: rtl/pg_precond.sv
module pg_precond
    import prog_gate_pkg::*;
(
    input  logic              dbg_en,
    input  logic              supply_ok,
    input  logic              preboot,
    input  logic [UNLK_W-1:0] unlock,
    output logic              gates_ok
);
    always_comb begin
        gates_ok = dbg_en && supply_ok && !preboot && (unlock == UNLK_CODE);
    end
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
    import prog_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_ok,
    input  logic gates_ok,
    input  logic secure,
    input  logic sel_erase,
    input  logic sel_read,
    input  logic erase_done,
    output logic active,
    output logic mode_erase,
    output logic mode_readback,
    output logic erase_start,
    output logic erase_busy
);
    pg_state_e state, state_nx;
    logic      req_ok;

    always_comb begin
        req_ok = key_wr && key_ok && gates_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PG_IDLE: begin
                if (req_ok && sel_erase)                 state_nx = PG_ERASE_KICK;
                else if (req_ok && sel_read && !secure)  state_nx = PG_READBACK;
            end
            PG_ERASE_KICK: state_nx = PG_ERASE_WAIT;
            PG_ERASE_WAIT: if (erase_done) state_nx = PG_ERASE_HOLD;
            PG_ERASE_HOLD: state_nx = PG_ERASE_HOLD;
            PG_READBACK:   state_nx = PG_READBACK;
            default:       state_nx = PG_IDLE;
        endcase
    end

    always_comb begin
        active        = 1'b0;
        mode_erase    = 1'b0;
        mode_readback = 1'b0;
        erase_start   = 1'b0;
        erase_busy    = 1'b0;
        unique case (state)
            PG_IDLE: ;
            PG_ERASE_KICK: begin
                active = 1'b1; mode_erase = 1'b1;
                erase_start = 1'b1; erase_busy = 1'b1;
            end
            PG_ERASE_WAIT: begin
                active = 1'b1; mode_erase = 1'b1; erase_busy = 1'b1;
            end
            PG_ERASE_HOLD: begin
                active = 1'b1; mode_erase = 1'b1;
            end
            PG_READBACK: begin
                active = 1'b1; mode_readback = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: entry only follows a 0x96 key write
    assert_entry_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(key_wr && key_ok));
    // R5: entry only with all gates satisfied
    assert_entry_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(gates_ok));
    // R6: read-back never entered under secure
    assert_secure_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_readback) |-> !$past(secure));
    // R8: the mode is sticky until reset
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (active && $stable(mode_erase) && $stable(mode_readback)));
    // R9: start pulse lasts one cycle
    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> (!erase_start && erase_busy));
    // R2: at most one mode indicated
    assert_one_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_erase, mode_readback}));
endmodule

// File: rtl/flash_pgm_gate.sv
module flash_pgm_gate
    import prog_gate_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h2080,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h2081
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              dbg_en,
    input  logic              supply_ok,
    input  logic              preboot,
    input  logic              secure,
    input  logic [3:0]        unlock,
    input  logic              erase_done,
    input  logic              irq_in,
    output logic              active,
    output logic              mode_erase,
    output logic              mode_readback,
    output logic              cpu_halt,
    output logic              irq_out,
    output logic              erase_start,
    output logic              erase_busy
);
    logic sel_wr, key_wr, key_ok, gates_ok, sel_erase, sel_read;

    pg_wr_decode #(.ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .KEY_ADDR(KEY_ADDR)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_wr(sel_wr), .key_wr(key_wr), .key_ok(key_ok)
    );

    pg_sel_reg u_sel (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .key_wr(key_wr),
        .wr_data(wr_data), .sel_erase(sel_erase), .sel_read(sel_read)
    );

    pg_precond u_pre (
        .dbg_en(dbg_en), .supply_ok(supply_ok), .preboot(preboot),
        .unlock(unlock), .gates_ok(gates_ok)
    );

    pg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_ok(key_ok),
        .gates_ok(gates_ok), .secure(secure), .sel_erase(sel_erase),
        .sel_read(sel_read), .erase_done(erase_done), .active(active),
        .mode_erase(mode_erase), .mode_readback(mode_readback),
        .erase_start(erase_start), .erase_busy(erase_busy)
    );

    always_comb begin
        cpu_halt = active;
        irq_out  = irq_in && !active;
    end

    // R7: halted processor receives no serial-path interrupt
    assert_halt_noirq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> (!irq_out && active));
endmodule

// File: tb/tb_flash_pgm_gate.sv
module tb_flash_pgm_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic dbg_en = 1'b0, supply_ok = 1'b0, preboot = 1'b0, secure = 1'b0;
    logic [3:0] unlock = '0;
    logic erase_done = 1'b0, irq_in = 1'b0;
    logic active, mode_erase, mode_readback, cpu_halt, irq_out, erase_start, erase_busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_pgm_gate dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dbg_en(dbg_en), .supply_ok(supply_ok), .preboot(preboot), .secure(secure),
        .unlock(unlock), .erase_done(erase_done), .irq_in(irq_in), .active(active),
        .mode_erase(mode_erase), .mode_readback(mode_readback), .cpu_halt(cpu_halt),
        .irq_out(irq_out), .erase_start(erase_start), .erase_busy(erase_busy)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic good_gates();
        dbg_en = 1'b1; supply_ok = 1'b1; preboot = 1'b0; secure = 1'b0; unlock = 4'b0010;
    endtask

    function automatic logic [1:0] expect_mode(input logic [7:0] sel, input logic [7:0] key,
        input logic d, input logic s, input logic p, input logic sec, input logic [3:0] u);
        logic g;
        g = d && s && !p && (u == 4'd2) && (key == 8'h96);
        if (g && sel == 8'hD1) return 2'b01;
        if (g && sel == 8'h2E && !sec) return 2'b10;
        return 2'b00;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        do_reset();
        chk({active, mode_erase, mode_readback, cpu_halt, erase_start, erase_busy}, 0, "R10 reset outputs");
        irq_in = 1'b1; @(negedge clk);
        chk(irq_out, 1, "R7 irq passes when idle");
        irq_in = 1'b0;

        // R5/R6/R2: sweep all gate combinations for three selector values
        for (int g = 0; g < 256; g++) begin
            for (int m = 0; m < 3; m++) begin
                logic [7:0] sel;
                logic [1:0] e;
                sel = (m == 0) ? 8'hD1 : (m == 1) ? 8'h2E : 8'h55;
                do_reset();
                dbg_en = g[0]; supply_ok = g[1]; preboot = g[2]; secure = g[3]; unlock = g[7:4];
                wr(16'h2080, sel);
                wr(16'h2081, 8'h96);
                e = expect_mode(sel, 8'h96, g[0], g[1], g[2], g[3], g[7:4]);
                chk({mode_readback, mode_erase}, e, "R5 R6 gate sweep mode");
                chk(active, (e != 0), "R5 gate sweep active");
            end
        end

        // R2: sweep all selector values
        for (int s = 0; s < 256; s++) begin
            do_reset(); good_gates();
            wr(16'h2080, s[7:0]);
            wr(16'h2081, 8'h96);
            chk({mode_readback, mode_erase}, expect_mode(s[7:0], 8'h96, 1, 1, 0, 0, 4'd2), "R2 selector sweep");
        end

        // R3/R4: key sweep, then a second 0x96 without re-arming
        for (int k = 0; k < 256; k++) begin
            do_reset(); good_gates();
            wr(16'h2080, 8'h2E);
            wr(16'h2081, k[7:0]);
            chk(active, (k == 8'h96), "R3 key sweep");
            if (k != 8'h96) begin
                wr(16'h2081, 8'h96);
                chk(active, 0, "R4 selector cleared by key write");
            end
        end

        // R1: selector byte at a wrong address
        do_reset(); good_gates();
        wr(16'h2082, 8'hD1); wr(16'h2081, 8'h96);
        chk(active, 0, "R1 wrong address ignored");
        wr(16'h0080, 8'hD1); wr(16'h2081, 8'h96);
        chk(active, 0, "R1 alias address ignored");
        wr(16'h2080, 8'hD1); wr(16'h3081, 8'h96);
        chk(active, 0, "R1 wrong key address");
        wr(16'h2081, 8'h96);
        chk(mode_erase, 1, "R1 true key address");

        // R9: erase sequence, done during kick ignored
        do_reset(); good_gates();
        wr(16'h2080, 8'hD1);
        @(negedge clk); wr_en = 1'b1; wr_addr = 16'h2081; wr_data = 8'h96;
        @(negedge clk); wr_en = 1'b0; erase_done = 1'b1;
        chk({erase_start, erase_busy, active}, 3'b111, "R9 kick cycle");
        @(negedge clk); erase_done = 1'b0;
        chk({erase_start, erase_busy}, 2'b01, "R9 done in kick ignored");
        repeat (3) @(negedge clk);
        chk({erase_start, erase_busy}, 2'b01, "R9 busy while waiting");
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        chk({erase_busy, mode_erase}, 2'b01, "R9 busy drops after done");

        // R7/R8: sticky while active, irq blocked
        irq_in = 1'b1; @(negedge clk);
        chk({cpu_halt, irq_out}, 2'b10, "R7 halt and irq blocked");
        irq_in = 1'b0;
        wr(16'h2080, 8'h2E); wr(16'h2081, 8'h00); wr(16'h2081, 8'h96);
        chk({active, mode_erase, mode_readback}, 3'b110, "R8 writes do not change mode");
        do_reset();
        chk({active, cpu_halt}, 0, "R8 reset leaves mode");

        // R6: secure refuses read-back but allows erase
        good_gates(); secure = 1'b1;
        wr(16'h2080, 8'h2E); wr(16'h2081, 8'h96);
        chk(active, 0, "R6 secure read-back refused");
        wr(16'h2080, 8'hD1); wr(16'h2081, 8'h96);
        chk(mode_erase, 1, "R6 secure erase allowed");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule